// File: doc/BRIEF.md
# Mesh Neighbour Link Register Unit

This block sits inside one processing element of a two-dimensional mesh and handles word traffic with the four adjacent elements. It owns four 32-bit outgoing link registers, one per side. The adjacent elements read those registers directly as their own incoming registers. The block also reads the four incoming registers that the neighbours drive. Each outgoing register carries a full flag. A write sets the flag, and the neighbour clears it by taking the word.

The unit executes two kinds of operation.

- A **send** places a word into one outgoing register. The word comes either from a general register, whose value is supplied on a port, or from another outgoing register.
- A **get** removes the word held in one incoming register. It delivers the word either to a general register, through a write port, or straight into an outgoing register.

The second form of get lets a word pass through the element in a single operation without touching its register file. When an operation cannot complete, a combinational stall holds the issuing element back. A get stalls while its incoming register is empty. A send or pass-through stalls while its target outgoing register is still full.

Top module: `mesh_link_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all four outgoing full flags are 0 and all outgoing registers read 0.
- R2: An accepted send whose source is a general register writes that value into the chosen outgoing register. It sets that register's full flag at the next clock edge and leaves the other registers unchanged.
- R3: The 2-bit direction code selects the link: 00 north, 01 east, 10 west, 11 south. On every link-indexed port vector, the element index equals the code.
- R4: An accepted get pulses exactly one take line, the one for the chosen incoming link, in the same cycle. When the destination is a general register, it also raises the register write enable with the incoming word as write data.
- R5: A get whose destination is general register 0 still takes the incoming word but raises no register write enable.
- R6: A get whose destination is an outgoing register copies the incoming word into that outgoing register and sets its full flag at the next edge, with no general register write.
- R7: A send whose source is an outgoing register copies that register's word into the chosen outgoing register. The source keeps its word and its flag.
- R8: A neighbour take on an outgoing register clears its full flag at the next edge and leaves its word unchanged.
- R9: A get on an incoming link whose neighbour flag is 0 raises stall, pulses no take line and writes nothing.
- R10: A send to an outgoing register whose flag is set raises stall and changes no outgoing register.
- R11: A pass-through get whose destination outgoing register is full raises stall and takes nothing.
- R12: With no operation valid, stall, take lines and register write enable are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_kind_i | input | 1 | 0 send, 1 get |
| op_dir_i | input | 2 | Link written by a send, or read by a get |
| op_reg_link_i | input | 1 | 1: the other operand is an outgoing register, not a general register |
| op_reg_dir_i | input | 2 | Outgoing register used as the other operand when op_reg_link_i is 1 |
| op_reg_addr_i | input | 5 | General register destination of a get |
| src_data_i | input | 32 | General register value for a send |
| op_stall_o | output | 1 | The presented operation cannot complete this cycle |
| gpr_we_o | output | 1 | General register write enable |
| gpr_waddr_o | output | 5 | General register write address |
| gpr_wdata_o | output | 32 | General register write data |
| in_data_i | input | 4x32 | Incoming registers, from the neighbours' outgoing registers |
| in_full_i | input | 4 | Neighbours' full flags for the incoming registers |
| in_take_o | output | 4 | Take pulse to each neighbour, which clears its flag |
| out_data_o | output | 4x32 | Outgoing registers |
| out_full_o | output | 4 | Full flags of the outgoing registers |
| out_take_i | input | 4 | Take pulse from each neighbour |

## Verification
A flag stuck or cleared wrongly inside this block shows up on out_full_o at the next clock edge. It also shows up in op_stall_o for the next send aimed at that link. A wrong direction decode shows up on the same cycle as a take pulse or write on the wrong element of a link vector. A corrupted pass-through or link-sourced copy is visible on out_data_o one edge after the operation. A flag that was lost instead of kept appears when the neighbour takes it.

// File: rtl/mlu_pkg.sv
package mlu_pkg;
  typedef enum logic [1:0] {
    LINK_NORTH = 2'b00,
    LINK_EAST  = 2'b01,
    LINK_WEST  = 2'b10,
    LINK_SOUTH = 2'b11
  } link_dir_e;

  typedef enum logic {
    OP_SEND = 1'b0,
    OP_GET  = 1'b1
  } link_op_e;
endpackage

// File: rtl/mlu_onehot_dec.sv
module mlu_onehot_dec #(
  parameter int N_OUT = 4,
  localparam int SEL_W = $clog2(N_OUT)
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  output logic [N_OUT-1:0] hot_o
);
  always_comb begin
    hot_o = '0;
    for (int k = 0; k < N_OUT; k++) begin
      if (en_i && (sel_i == SEL_W'(k))) hot_o[k] = 1'b1;
    end
  end
endmodule

// File: rtl/mlu_link_slot.sv
module mlu_link_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              full_q, full_d;
  logic              data_en;

  always_comb begin
    data_en = wr_en_i;
    data_d  = wr_data_i;
    full_d  = full_q;
    if (take_i)  full_d = 1'b0;
    if (wr_en_i) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take_i) |-> !wr_en_i); // R10

  AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (full_o && data_o == $past(wr_data_i))); // R2

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !wr_en_i) |=> (!full_o && $stable(data_o))); // R8
endmodule

// File: rtl/mesh_link_unit.sv
module mesh_link_unit
  import mlu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_LINKS = 4,
  parameter int GPR_AW    = 5,
  localparam int DIR_W    = $clog2(NUM_LINKS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              op_valid_i,
  input  logic                              op_kind_i,
  input  logic [DIR_W-1:0]                  op_dir_i,
  input  logic                              op_reg_link_i,
  input  logic [DIR_W-1:0]                  op_reg_dir_i,
  input  logic [GPR_AW-1:0]                 op_reg_addr_i,
  input  logic [DATA_W-1:0]                 src_data_i,
  output logic                              op_stall_o,
  output logic                              gpr_we_o,
  output logic [GPR_AW-1:0]                 gpr_waddr_o,
  output logic [DATA_W-1:0]                 gpr_wdata_o,
  input  logic [NUM_LINKS-1:0][DATA_W-1:0]  in_data_i,
  input  logic [NUM_LINKS-1:0]              in_full_i,
  output logic [NUM_LINKS-1:0]              in_take_o,
  output logic [NUM_LINKS-1:0][DATA_W-1:0]  out_data_o,
  output logic [NUM_LINKS-1:0]              out_full_o,
  input  logic [NUM_LINKS-1:0]              out_take_i
);
  logic              is_get;
  logic              can_go;
  logic              accept;
  logic              wr_any;
  logic [DIR_W-1:0]  wr_dir;
  logic [DATA_W-1:0] wr_word;
  logic [NUM_LINKS-1:0] wr_hot;

  always_comb begin
    is_get = (link_op_e'(op_kind_i) == OP_GET);
    if (is_get) begin
      can_go = in_full_i[op_dir_i] && !(op_reg_link_i && out_full_o[op_reg_dir_i]);
    end else begin
      can_go = !out_full_o[op_dir_i];
    end
    accept     = op_valid_i && can_go;
    op_stall_o = op_valid_i && !can_go;

    wr_any  = accept && (!is_get || op_reg_link_i);
    wr_dir  = is_get ? op_reg_dir_i : op_dir_i;
    if (is_get)             wr_word = in_data_i[op_dir_i];
    else if (op_reg_link_i) wr_word = out_data_o[op_reg_dir_i];
    else                    wr_word = src_data_i;

    gpr_we_o    = accept && is_get && !op_reg_link_i && (op_reg_addr_i != '0);
    gpr_waddr_o = op_reg_addr_i;
    gpr_wdata_o = in_data_i[op_dir_i];
  end

  mlu_onehot_dec #(.N_OUT(NUM_LINKS)) u_take_dec (
    .sel_i (op_dir_i),
    .en_i  (accept && is_get),
    .hot_o (in_take_o)
  );

  mlu_onehot_dec #(.N_OUT(NUM_LINKS)) u_wr_dec (
    .sel_i (wr_dir),
    .en_i  (wr_any),
    .hot_o (wr_hot)
  );

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_slot
    mlu_link_slot #(.DATA_W(DATA_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_hot[g]),
      .wr_data_i (wr_word),
      .take_i    (out_take_i[g]),
      .data_o    (out_data_o[g]),
      .full_o    (out_full_o[g])
    );
  end

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    op_stall_o |-> (in_take_o == '0 && !gpr_we_o)); // R9

  AST_TAKE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_take_o)); // R4

  AST_TAKE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_take_o & ~in_full_i) == '0)); // R9

  AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_we_o |-> (gpr_waddr_o != '0)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |-> (!op_stall_o && in_take_o == '0 && !gpr_we_o)); // R12
endmodule

// File: tb/tb_mesh_link_unit.sv
module tb_mesh_link_unit;
  localparam int CLK_PERIOD = 10;

  logic             clk, rst_n;
  logic             op_valid, op_kind, op_link;
  logic [1:0]       op_dir, op_rdir;
  logic [4:0]       op_addr;
  logic [31:0]      src_data;
  logic             stall, gpr_we;
  logic [4:0]       gpr_waddr;
  logic [31:0]      gpr_wdata;
  logic [3:0][31:0] in_data;
  logic [3:0]       in_full, in_take;
  logic [3:0][31:0] out_data;
  logic [3:0]       out_full, out_take;

  int n_checks = 0;
  int n_fail   = 0;

  mesh_link_unit dut (
    .clk(clk), .rst_n(rst_n),
    .op_valid_i(op_valid), .op_kind_i(op_kind), .op_dir_i(op_dir),
    .op_reg_link_i(op_link), .op_reg_dir_i(op_rdir), .op_reg_addr_i(op_addr),
    .src_data_i(src_data), .op_stall_o(stall),
    .gpr_we_o(gpr_we), .gpr_waddr_o(gpr_waddr), .gpr_wdata_o(gpr_wdata),
    .in_data_i(in_data), .in_full_i(in_full), .in_take_o(in_take),
    .out_data_o(out_data), .out_full_o(out_full), .out_take_i(out_take)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        v;
    logic        kind;
    logic [1:0]  dir;
    logic        lnk;
    logic [1:0]  rdir;
    logic [4:0]  addr;
    logic [31:0] sdata;
    logic [3:0]  infull;
    logic [3:0]  otake;
    logic        e_stall;
    logic        e_we;
    logic [3:0]  e_take;
    logic [3:0]  e_full;
    logic [1:0]  chk;
    logic [31:0] e_word;
  } vec_t;

  // Rows run in order; flag state carries from one row to the next.
  localparam vec_t TBL [10] = '{
    // R2 R3: send general value north
    '{1'b1,1'b0,2'd0,1'b0,2'd0,5'd0,32'h1111_1111,4'b0000,4'b0000,1'b0,1'b0,4'b0000,4'b0001,2'd0,32'h1111_1111},
    // R2 R3: send general value south
    '{1'b1,1'b0,2'd3,1'b0,2'd0,5'd0,32'h3333_3333,4'b0000,4'b0000,1'b0,1'b0,4'b0000,4'b1001,2'd3,32'h3333_3333},
    // R10: send to full north stalls, word kept
    '{1'b1,1'b0,2'd0,1'b0,2'd0,5'd0,32'hDEAD_BEEF,4'b0000,4'b0000,1'b1,1'b0,4'b0000,4'b1001,2'd0,32'h1111_1111},
    // R4: get east into r5
    '{1'b1,1'b1,2'd1,1'b0,2'd0,5'd5,32'h0,4'b0010,4'b0000,1'b0,1'b1,4'b0010,4'b1001,2'd3,32'h3333_3333},
    // R5: get west into r0
    '{1'b1,1'b1,2'd2,1'b0,2'd0,5'd0,32'h0,4'b0100,4'b0000,1'b0,1'b0,4'b0100,4'b1001,2'd3,32'h3333_3333},
    // R9: get north while empty stalls
    '{1'b1,1'b1,2'd0,1'b0,2'd0,5'd7,32'h0,4'b0000,4'b0000,1'b1,1'b0,4'b0000,4'b1001,2'd0,32'h1111_1111},
    // R6: pass-through west in -> east out
    '{1'b1,1'b1,2'd2,1'b1,2'd1,5'd0,32'h0,4'b0100,4'b0000,1'b0,1'b0,4'b0100,4'b1011,2'd1,32'hA0A0_0002},
    // R11: pass-through into full south stalls
    '{1'b1,1'b1,2'd1,1'b1,2'd3,5'd0,32'h0,4'b0010,4'b0000,1'b1,1'b0,4'b0000,4'b1011,2'd3,32'h3333_3333},
    // R8 R12: idle, neighbour takes north
    '{1'b0,1'b0,2'd0,1'b0,2'd0,5'd0,32'h0,4'b1111,4'b0001,1'b0,1'b0,4'b0000,4'b1010,2'd0,32'h1111_1111},
    // R7: send from south outgoing into north
    '{1'b1,1'b0,2'd0,1'b1,2'd3,5'd0,32'h0,4'b0000,4'b0000,1'b0,1'b0,4'b0000,4'b1011,2'd0,32'h3333_3333}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 1'b0; op_kind = 1'b0; op_dir = 2'd0; op_link = 1'b0;
    op_rdir = 2'd0; op_addr = 5'd0; src_data = '0;
    in_full = '0; out_take = '0;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) in_data[k] = 32'hA0A0_0000 + k;
    idle_inputs();
    rst_n = 1'b0;
    #1;
    check(out_full == 4'b0000, "R1 flags in reset", 64'(out_full), 64'h0);
    check(out_data == '0, "R1 data in reset", 64'(out_data[0]), 64'h0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_full == 4'b0000, "R1 flags after reset", 64'(out_full), 64'h0);
    check(!stall && !gpr_we && in_take == '0, "R12 idle outputs", 64'({stall, gpr_we, in_take}), 64'h0);

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      op_valid = TBL[i].v;    op_kind = TBL[i].kind; op_dir = TBL[i].dir;
      op_link  = TBL[i].lnk;  op_rdir = TBL[i].rdir; op_addr = TBL[i].addr;
      src_data = TBL[i].sdata; in_full = TBL[i].infull; out_take = TBL[i].otake;
      #1;
      check(stall == TBL[i].e_stall, $sformatf("R9/R10/R11 stall row %0d", i), 64'(stall), 64'(TBL[i].e_stall));
      check(gpr_we == TBL[i].e_we, $sformatf("R4/R5 write enable row %0d", i), 64'(gpr_we), 64'(TBL[i].e_we));
      check(in_take == TBL[i].e_take, $sformatf("R3/R4 take row %0d", i), 64'(in_take), 64'(TBL[i].e_take));
      if (TBL[i].e_we) begin
        check(gpr_wdata == in_data[TBL[i].dir] && gpr_waddr == TBL[i].addr,
              $sformatf("R4 write data row %0d", i), 64'(gpr_wdata), 64'(in_data[TBL[i].dir]));
      end
      @(posedge clk);
      #1;
      check(out_full == TBL[i].e_full, $sformatf("R2/R6/R8 flags row %0d", i), 64'(out_full), 64'(TBL[i].e_full));
      check(out_data[TBL[i].chk] == TBL[i].e_word, $sformatf("R2/R6/R7 word row %0d", i),
            64'(out_data[TBL[i].chk]), 64'(TBL[i].e_word));
    end

    // R7: link source keeps its word and flag
    check(out_full[3] && out_data[3] == 32'h3333_3333, "R7 source kept", 64'(out_data[3]), 64'h3333_3333);
    // R3: east slot still holds the word passed through from the west link
    check(out_data[1] == 32'hA0A0_0002, "R3 east slot word", 64'(out_data[1]), 64'hA0A0_0002);

    // R8: take on east, data kept
    @(negedge clk);
    idle_inputs();
    out_take = 4'b0010;
    @(posedge clk);
    #1;
    check(out_full == 4'b1001, "R8 east take flags", 64'(out_full), 64'h9);
    check(out_data[1] == 32'hA0A0_0002, "R8 east data kept", 64'(out_data[1]), 64'hA0A0_0002);

    // R12: idle with every neighbour full, nothing taken
    @(negedge clk);
    idle_inputs();
    in_full = 4'b1111;
    #1;
    check(in_take == 4'b0000 && !gpr_we && !stall, "R12 idle with full neighbours",
          64'({stall, gpr_we, in_take}), 64'h0);

    // R1: mid-run reset clears everything
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    #1;
    check(out_full == 4'b0000 && out_data == '0, "R1 mid-run reset", 64'(out_full), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_full == 4'b0000, "R1 after mid-run reset", 64'(out_full), 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule